// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the event bookkeeping for a byte-oriented serial bus master: a stored status word of pending events, an interrupt enable mask and a DMA enable register. The transfer logic and the data buffer raise and drop individual status bits through per-bit set and clear strobes. The unit turns the enabled events into one combined interrupt line and turns the two ready flags into receive and transmit DMA requests.

A host reaches the unit through a 16-bit register port with a read strobe, a write strobe and a 3-bit address. A build-time parameter picks one of two revisions. The legacy revision acknowledges events by reading a vector register: each read returns a code for the lowest enabled pending event and clears that event. The newer revision has no vector register. Instead, the host clears selected status bits by writing ones to them, and a force register can set all six low event bits at once for testing.

Register addresses: 0 status, 1 interrupt enable, 2 DMA enable, 3 vector, 4 force. Status bit positions are: 0 general event, 1 no-acknowledge, 2 access-ready, 3 receive-ready, 4 transmit-ready, 5 general event, 10 transmit underflow, 11 receive overrun, 15 single-byte data. Any other status bit is not stored and reads as zero, except bit 12.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word, the enable mask and the DMA register read as zero, and `irq`, `drq_rx` and `drq_tx` are low.
- R2: A one on `hw_set[i]` sets stored status bit i at the clock edge. A one on `hw_clr[i]`, a host write-one-to-clear or a vector acknowledge clears it. When a set and any clear hit the same bit in the same cycle, the set wins. Only bits 0-5, 10, 11 and 15 are stored.
- R3: A read of address 0 returns the stored status word with bit 12 replaced by the live `bus_busy` input.
- R4: `irq` is high in the cycle after one in which (status[5:0] AND mask) is nonzero, and low otherwise.
- R5: On the legacy revision, `rdata` at address 3 is the index of the lowest set bit of (status[5:0] AND mask) plus one, or 0 when none is set. A read strobe at that address clears the returned bit at the clock edge.
- R6: On the newer revision, address 3 reads 0 and its read has no effect. A write to address 0 clears the status bits where wdata is one, limited to bits 0, 1, 2 and 5. On the legacy revision, a write to address 0 has no effect.
- R7: A write to address 1 stores wdata[4:0] on the legacy revision and wdata[5:0] on the newer revision. Reads of address 1 return the stored bits.
- R8: A write to address 2 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A one in bit 15 clears mask bit 3, and a one in bit 7 clears mask bit 4.
- R9: `drq_rx` is high in the cycle after one in which DMA bit 15 and status bit 3 are both set. `drq_tx` does the same for DMA bit 7 and status bit 4.
- R10: On the newer revision, a write to address 4 with wdata bit 11 set forces status bits 5..0 to one. On the legacy revision this write has no effect. Address 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | Live bus-busy flag, shown in status bit 12 |
| hw_set | input | 16 | Per-bit status set strobes from the transfer logic |
| hw_clr | input | 16 | Per-bit status clear strobes from the transfer logic |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current address |
| irq | output | 1 | Combined interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |

## Verification
The bench runs both revisions side by side on the same stimulus.

It collides a hardware set with a hardware clear and a host clear on one bit. A design that lets the clear win would lose a fresh event.

It reads the vector register with several events pending, and again with none pending. A design that picks the highest event, forgets the plus-one code or fails to clear the bit would return the same code again or a wrong code.

It writes the DMA register and then reads back the mask. It also writes all ones to the status word and to the mask on each revision. These steps catch a missing mask drop, a w1c that reaches the receive-ready or transmit-ready bits, or a sixth mask bit on the legacy build.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_DMA    = 3'd2,
    RA_VECTOR = 3'd3,
    RA_FORCE  = 3'd4
  } reg_addr_e;

  localparam int unsigned WORD_W     = 16;
  localparam int unsigned EVT_N      = 6;
  localparam logic [WORD_W-1:0] STAT_KEEP = 16'h8C3F;
  localparam logic [WORD_W-1:0] W1C_NEW   = 16'h0027;
  localparam logic [WORD_W-1:0] DMA_KEEP  = 16'h8080;
  localparam int unsigned BUSY_BIT   = 12;
  localparam int unsigned RXDMA_BIT  = 15;
  localparam int unsigned TXDMA_BIT  = 7;
  localparam int unsigned RRDY_BIT   = 3;
  localparam int unsigned XRDY_BIT   = 4;
  localparam int unsigned FORCE_BIT  = 11;
endpackage

// File: rtl/iss_vector_enc.sv
module iss_vector_enc #(
  parameter int unsigned N     = 6,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit    = 1'b1;
        idx    = IDX_W'(i);
        onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/iss_status_reg.sv
module iss_status_reg #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  logic [W-1:0] status_d;
  logic         status_en;

  always_comb begin
    status_d  = ((status_q & ~clr_vec) | set_vec) & KEEP;
    status_en = |((set_vec | clr_vec) & KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/iss_out_regs.sv
module iss_out_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_d,
  input  logic drq_rx_d,
  input  logic drq_tx_d,
  output logic irq_q,
  output logic drq_rx_q,
  output logic drq_tx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      drq_rx_q <= 1'b0;
      drq_tx_q <= 1'b0;
    end else begin
      irq_q    <= irq_d;
      drq_rx_q <= drq_rx_d;
      drq_tx_q <= drq_tx_d;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import iss_pkg::*;
#(
  parameter bit LEGACY = 1'b0,
  localparam int unsigned IDX_W = $clog2(EVT_N),
  localparam logic [EVT_N-1:0] MASK_KEEP = LEGACY ? 6'h1F : 6'h3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic [WORD_W-1:0] hw_set,
  input  logic [WORD_W-1:0] hw_clr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq,
  output logic              drq_rx,
  output logic              drq_tx
);
  logic [WORD_W-1:0] status_q;
  logic [EVT_N-1:0]  mask_q, mask_d;
  logic              mask_en;
  logic [WORD_W-1:0] dma_q, dma_d;
  logic              dma_en;
  logic [EVT_N-1:0]  pend;
  logic              vec_hit;
  logic [IDX_W-1:0]  vec_idx;
  logic [EVT_N-1:0]  vec_onehot;
  logic [WORD_W-1:0] vec_code;
  logic              vec_ack;
  logic [WORD_W-1:0] host_clr, force_set;
  logic [WORD_W-1:0] set_all, clr_all;

  wire wr_status = wr_en && (addr == RA_STATUS);
  wire wr_enable = wr_en && (addr == RA_ENABLE);
  wire wr_dma    = wr_en && (addr == RA_DMA);
  wire wr_force  = wr_en && (addr == RA_FORCE);
  wire rd_vector = rd_en && (addr == RA_VECTOR);

  assign pend = status_q[EVT_N-1:0] & mask_q;

  // Revision picks the acknowledge path.
  if (LEGACY) begin : g_vec
    iss_vector_enc #(.N(EVT_N)) u_enc (
      .pend   (pend),
      .hit    (vec_hit),
      .idx    (vec_idx),
      .onehot (vec_onehot)
    );
    assign vec_code  = vec_hit ? (WORD_W'(vec_idx) + WORD_W'(1)) : '0;
    assign vec_ack   = rd_vector && vec_hit;
    assign host_clr  = vec_ack ? WORD_W'(vec_onehot) : '0;
    assign force_set = '0;
  end else begin : g_w1c
    assign vec_hit    = 1'b0;
    assign vec_idx    = '0;
    assign vec_onehot = '0;
    assign vec_code   = '0;
    assign vec_ack    = 1'b0;
    assign host_clr   = wr_status ? (wdata & W1C_NEW) : '0;
    assign force_set  = (wr_force && wdata[FORCE_BIT]) ? WORD_W'({EVT_N{1'b1}}) : '0;
  end

  assign set_all = hw_set | force_set;
  assign clr_all = hw_clr | host_clr;

  iss_status_reg #(.W(WORD_W), .KEEP(STAT_KEEP)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_all),
    .clr_vec  (clr_all),
    .status_q (status_q)
  );

  // Enable mask and DMA register next state
  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    dma_d   = dma_q;
    dma_en  = 1'b0;
    if (wr_enable) begin
      mask_d  = wdata[EVT_N-1:0] & MASK_KEEP;
      mask_en = 1'b1;
    end
    if (wr_dma) begin
      dma_d  = wdata & DMA_KEEP;
      dma_en = 1'b1;
      if (wdata[RXDMA_BIT]) begin mask_d[RRDY_BIT] = 1'b0; mask_en = 1'b1; end
      if (wdata[TXDMA_BIT]) begin mask_d[XRDY_BIT] = 1'b0; mask_en = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dma_q <= '0;
    else if (dma_en) dma_q <= dma_d;
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      RA_STATUS: begin
        rdata           = status_q;
        rdata[BUSY_BIT] = bus_busy;
      end
      RA_ENABLE: rdata = WORD_W'(mask_q);
      RA_DMA:    rdata = dma_q;
      RA_VECTOR: rdata = vec_code;
      default:   rdata = '0;
    endcase
  end

  iss_out_regs u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_d    (|pend),
    .drq_rx_d (dma_q[RXDMA_BIT] & status_q[RRDY_BIT]),
    .drq_tx_d (dma_q[TXDMA_BIT] & status_q[XRDY_BIT]),
    .irq_q    (irq),
    .drq_rx_q (drq_rx),
    .drq_tx_q (drq_tx)
  );
endmodule

// File: rtl/iss_checker.sv
module iss_checker
  import iss_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] hw_set,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [WORD_W-1:0] wdata,
  input logic [WORD_W-1:0] status_q,
  input logic [EVT_N-1:0]  mask_q,
  input logic [WORD_W-1:0] dma_q,
  input logic              irq,
  input logic              drq_rx,
  input logic              drq_tx
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((($past(hw_set) & STAT_KEEP) & ~status_q) == '0));

  a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq == $past(|(status_q[EVT_N-1:0] & mask_q))));

  a_r9_drq_rx: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (drq_rx == $past(dma_q[RXDMA_BIT] & status_q[RRDY_BIT])));

  a_r9_drq_tx: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (drq_tx == $past(dma_q[TXDMA_BIT] & status_q[XRDY_BIT])));

  a_r8_dma_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_en && addr == RA_DMA && wdata[RXDMA_BIT])) |-> !mask_q[RRDY_BIT]);

  a_r7_legacy_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (LEGACY && past_ok) |-> !mask_q[EVT_N-1]);
endmodule

bind irq_status_unit iss_checker #(.LEGACY(LEGACY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hw_set   (hw_set),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .status_q (status_q),
  .mask_q   (mask_q),
  .dma_q    (dma_q),
  .irq      (irq),
  .drq_rx   (drq_rx),
  .drq_tx   (drq_tx)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  logic        clk;
  logic        rst_n;
  logic        bus_busy;
  logic [15:0] hw_set, hw_clr, wdata;
  logic        rd_en, wr_en;
  logic [2:0]  addr;
  logic [15:0] rdata_n, rdata_l;
  logic        irq_n, drq_rx_n, drq_tx_n;
  logic        irq_l, drq_rx_l, drq_tx_l;

  int errors = 0;
  int checks = 0;

  // model state: index 0 = newer revision, 1 = legacy revision
  logic [15:0] m_stat [2];
  logic [5:0]  m_mask [2];
  logic [15:0] m_dma  [2];
  logic        e_irq  [2];
  logic        e_rx   [2];
  logic        e_tx   [2];

  irq_status_unit #(.LEGACY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .hw_set(hw_set), .hw_clr(hw_clr),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata_n),
    .irq(irq_n), .drq_rx(drq_rx_n), .drq_tx(drq_tx_n));

  irq_status_unit #(.LEGACY(1'b1)) dut_leg (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .hw_set(hw_set), .hw_clr(hw_clr),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata_l),
    .irq(irq_l), .drq_rx(drq_rx_l), .drq_tx(drq_tx_l));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] lowest(input logic [5:0] p);
    logic [15:0] r;
    r = '0;
    for (int i = 5; i >= 0; i--) if (p[i]) r = 16'(1) << i;
    return r;
  endfunction

  function automatic logic [15:0] vcode(input logic [5:0] p);
    logic [15:0] r;
    r = '0;
    for (int i = 5; i >= 0; i--) if (p[i]) r = 16'(i + 1);
    return r;
  endfunction

  function automatic logic [15:0] exp_rd(input int k, input logic [2:0] a, input logic busy);
    logic [15:0] r;
    r = '0;
    case (a)
      3'd0: begin r = m_stat[k]; r[12] = busy; end
      3'd1: r = 16'(m_mask[k]);
      3'd2: r = m_dma[k];
      3'd3: r = (k == 1) ? vcode(m_stat[k][5:0] & m_mask[k]) : 16'h0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int k, input logic [2:0] a);
    case (a)
      3'd0: return "R2,R3";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return (k == 1) ? "R5" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step(input int k);
    logic [15:0] clr, set;
    logic        leg;
    leg = (k == 1);
    e_irq[k] = |(m_stat[k][5:0] & m_mask[k]);
    e_rx[k]  = m_dma[k][15] & m_stat[k][3];
    e_tx[k]  = m_dma[k][7]  & m_stat[k][4];
    clr = hw_clr;
    set = hw_set;
    if (wr_en && addr == 3'd0 && !leg) clr |= wdata & 16'h0027;
    if (rd_en && addr == 3'd3 && leg)  clr |= lowest(m_stat[k][5:0] & m_mask[k]);
    if (wr_en && addr == 3'd4 && !leg && wdata[11]) set |= 16'h003F;
    m_stat[k] = ((m_stat[k] & ~clr) | set) & 16'h8C3F;
    if (wr_en && addr == 3'd1) m_mask[k] = wdata[5:0] & (leg ? 6'h1F : 6'h3F);
    if (wr_en && addr == 3'd2) begin
      m_dma[k] = wdata & 16'h8080;
      if (wdata[15]) m_mask[k][3] = 1'b0;
      if (wdata[7])  m_mask[k][4] = 1'b0;
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic [2:0] a, input logic [15:0] wd,
                     input logic [15:0] st, input logic [15:0] cl, input logic busy);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; hw_set = st; hw_clr = cl; bus_busy = busy;
    #1;
    chk(tag_of(0, a), "newer rdata", rdata_n, exp_rd(0, a, busy));
    chk(tag_of(1, a), "legacy rdata", rdata_l, exp_rd(1, a, busy));
    model_step(0);
    model_step(1);
    @(posedge clk);
    #2;
    chk("R4", "newer irq",  16'(irq_n), 16'(e_irq[0]));
    chk("R4", "legacy irq", 16'(irq_l), 16'(e_irq[1]));
    chk("R9", "newer drq_rx",  16'(drq_rx_n), 16'(e_rx[0]));
    chk("R9", "newer drq_tx",  16'(drq_tx_n), 16'(e_tx[0]));
    chk("R9", "legacy drq_rx", 16'(drq_rx_l), 16'(e_rx[1]));
    chk("R9", "legacy drq_tx", 16'(drq_tx_l), 16'(e_tx[1]));
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b1, 1'b0, a, 16'h0, 16'h0, 16'h0, 1'b0);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [2:0]  a;
    logic [15:0] st, cl, wd;
    int op;
    seed = 32'h1234_5A5A;
    void'($urandom(seed));
    rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0; hw_set = 0; hw_clr = 0; bus_busy = 0;
    for (int k = 0; k < 2; k++) begin
      m_stat[k] = 0; m_mask[k] = 0; m_dma[k] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "irq after reset", 16'({irq_n, irq_l}), 16'h0);
    chk("R1", "drq after reset", 16'({drq_rx_n, drq_tx_n, drq_rx_l, drq_tx_l}), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0);
    rd(3'd1);
    rd(3'd2);
    // R3: live busy bit
    cyc(1'b1, 1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 1'b1);
    // R10: force on newer only
    cyc(1'b0, 1'b1, 3'd4, 16'h0800, 16'h0, 16'h0, 1'b0);
    rd(3'd0);
    rd(3'd4);
    // R7: mask widths
    cyc(1'b0, 1'b1, 3'd1, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    rd(3'd1);
    // R5: vector sequence on legacy (events at bits 2 and 4)
    cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0014, 16'h0, 1'b0);
    rd(3'd3);
    rd(3'd3);
    rd(3'd3);
    rd(3'd0);
    // R2: set beats hardware clear and host clear on bit 3 and bit 1
    cyc(1'b0, 1'b1, 3'd0, 16'h0002, 16'h000A, 16'h000A, 1'b0);
    rd(3'd0);
    // R6: newer w1c of all ones leaves bits 3, 4 and high bits
    cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h8C18, 16'h0, 1'b0);
    cyc(1'b0, 1'b1, 3'd0, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    rd(3'd0);
    // R8: DMA enable drops mask bits 3 and 4
    cyc(1'b0, 1'b1, 3'd2, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    rd(3'd2);
    rd(3'd1);
    rd(3'd1);
    // R9: DMA request from ready flags
    cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0018, 16'h0, 1'b0);
    rd(3'd0);
    cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0, 16'h0018, 1'b0);
    rd(3'd0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      op = $urandom_range(0, 9);
      a  = 3'($urandom_range(0, 4));
      wd = 16'($urandom);
      st = 16'($urandom) & 16'($urandom) & 16'($urandom);
      cl = 16'($urandom) & 16'($urandom);
      if (op < 4)      cyc(1'b1, 1'b0, a, wd, st, cl, 1'($urandom));
      else if (op < 7) cyc(1'b0, 1'b1, a, wd, st, cl, 1'($urandom));
      else             cyc(1'b0, 1'b0, a, wd, st, cl, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule